// File: doc/BRIEF.md
# Unaligned Word Bus Access Unit

This unit sits between a requester that asks for bytes or 16-bit words at any byte address and a memory that only accepts word-aligned reads on a 16-bit data path. Each address in the 20-bit space names one byte. A word occupies two neighbouring addresses, and its less significant byte sits at the lower address. The unit turns each request into one or two aligned bus reads. It then moves the right byte lanes into a 16-bit result and returns that result over a valid/ready response channel.

A word at an even address needs one bus read. A word at an odd address needs two reads. The first read fetches the aligned word just below the address, and the unit keeps its upper lane. The second read fetches the next aligned word, and the unit keeps its lower lane. A byte request always needs one read, from the aligned word that contains the byte. The wanted lane goes to the low result byte, and the upper result byte is filled with zeros. The unit accepts one request at a time. The response is raised only after every bus read for that request has returned.

Top module: `lane_merge_reader`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: Every address presented on `mem_req_addr` has bit 0 equal to 0.
- R3: A word request (`req_byte`=0) at an even address A makes exactly one bus read, at A. `rsp_data` equals the fetched word unchanged: bits 7:0 are the byte at A and bits 15:8 are the byte at A+1.
- R4: A word request at an odd address A makes exactly two bus reads, first at A-1 and then at A+1. `rsp_data[7:0]` is bits 15:8 of the first fetched word, and `rsp_data[15:8]` is bits 7:0 of the second.
- R5: A byte request (`req_byte`=1) at an even address A makes one bus read, at A. `rsp_data[7:0]` is bits 7:0 of the fetched word, and `rsp_data[15:8]` is 0, whatever the upper lane held.
- R6: A byte request at an odd address A makes one bus read, at A-1. `rsp_data[7:0]` is bits 15:8 of the fetched word, and `rsp_data[15:8]` is 0, whatever the lower lane held.
- R7: Bus addresses wrap modulo 2^20. A word request at 0xFFFFF reads 0xFFFFE first and 0x00000 second.
- R8: Once `rsp_valid` is 1, it stays 1 and `rsp_data` stays unchanged until a cycle with `rsp_ready` high. `rsp_valid` is never 1 while a bus read is still awaited.
- R9: After a request is accepted, `req_ready` stays 0 until the response has been taken.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_valid` and `mem_req_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester offers a read |
| req_ready | output | 1 | Unit can accept a read |
| req_addr | input | 20 | Byte address of the read |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_data | output | 16 | Result, low byte from the lower address |
| mem_req_valid | output | 1 | Aligned bus read offered |
| mem_req_ready | input | 1 | Memory accepts the bus read |
| mem_req_addr | output | 20 | Word-aligned bus address |
| mem_rsp_valid | input | 1 | Memory returns a word |
| mem_rsp_ready | output | 1 | Unit can take a returned word |
| mem_rsp_data | input | 16 | Returned word, bits 7:0 from the even address |

## Verification
The test memory returns a word whose two lanes differ and depend on the address, so a swapped lane, a shifted address or a stale word each produce a wrong value. Word reads at even and odd addresses show whether the unit splits the read and where it takes each lane. Byte reads at even and odd addresses show which single lane is kept and whether the upper result byte is cleared. Reads at the top of the address space test the wrap. A long run of random requests, with random stalls on both sides, tests the hold rules and the count of bus reads per request.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE_A,
      ST_WAIT_A,
      ST_ISSUE_B,
      ST_WAIT_B,
      ST_DONE
   } lmr_state_e;

   typedef struct packed {
      logic is_byte;
      logic odd;
   } lmr_kind_t;

   function automatic logic needs_split(lmr_kind_t k);
      return !k.is_byte && k.odd;
   endfunction

endpackage

// File: rtl/lmr_seq.sv
module lmr_seq
   import lmr_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_byte,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   output logic              mem_rsp_ready,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] base_addr,
   output logic              second_phase,
   output lmr_kind_t         kind,
   output logic              cap_first,
   output logic              cap_second
);

   lmr_state_e state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   lmr_kind_t kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         kind_q  <= '0;
      end else begin
         state_q <= state_d;
         if (req_valid && req_ready) begin
            addr_q         <= req_addr;
            kind_q.is_byte <= req_byte;
            kind_q.odd     <= req_addr[0];
         end
      end
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (req_valid)     state_d = ST_ISSUE_A;
         ST_ISSUE_A: if (mem_req_ready) state_d = ST_WAIT_A;
         ST_WAIT_A:  if (mem_rsp_valid) state_d = needs_split(kind_q) ? ST_ISSUE_B : ST_DONE;
         ST_ISSUE_B: if (mem_req_ready) state_d = ST_WAIT_B;
         ST_WAIT_B:  if (mem_rsp_valid) state_d = ST_DONE;
         ST_DONE:    if (rsp_ready)     state_d = ST_IDLE;
         default:                       state_d = ST_IDLE;
      endcase
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_ISSUE_A) || (state_q == ST_ISSUE_B);
   assign mem_rsp_ready = (state_q == ST_WAIT_A) || (state_q == ST_WAIT_B);
   assign rsp_valid     = (state_q == ST_DONE);
   assign second_phase  = (state_q == ST_ISSUE_B);
   assign cap_first     = (state_q == ST_WAIT_A) && mem_rsp_valid;
   assign cap_second    = (state_q == ST_WAIT_B) && mem_rsp_valid;
   assign base_addr     = addr_q;
   assign kind          = kind_q;

   // R10: an offered bus read is held until it is accepted
   a_r10_mreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(second_phase) && $stable(base_addr));

   // R8: the response stays up until it is taken
   a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid);

   // R4: the second bus read belongs only to a split word request
   a_r4_second_only_split: assert property (@(posedge clk) disable iff (!rst_n)
      second_phase |-> (!kind.is_byte && base_addr[0]));

endmodule

// File: rtl/lmr_addr_gen.sv
module lmr_addr_gen #(
   parameter int ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              second_phase,
   output logic [ADDR_W-1:0] bus_addr
);

   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W-1:0] next_word;

   assign aligned   = {base_addr[ADDR_W-1:1], 1'b0};
   // the sum drops its carry, so the next word after the top one is word 0
   assign next_word = aligned + WORD_STEP;
   assign bus_addr  = second_phase ? next_word : aligned;

endmodule

// File: rtl/lmr_lane_steer.sv
module lmr_lane_steer
   import lmr_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter bit SIGN_FILL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  lmr_kind_t           kind,
   input  logic                cap_first,
   input  logic                cap_second,
   input  logic [2*LANE_W-1:0] bus_word,
   output logic [2*LANE_W-1:0] result
);

   logic [LANE_W-1:0] lane_lo, lane_hi;
   logic [LANE_W-1:0] pick_lo, fill_v;
   logic [LANE_W-1:0] res_lo_q, res_hi_q;

   assign lane_lo = bus_word[LANE_W-1:0];
   assign lane_hi = bus_word[2*LANE_W-1:LANE_W];
   assign pick_lo = kind.odd ? lane_hi : lane_lo;

   generate
      if (SIGN_FILL) begin : g_sign_fill
         assign fill_v = {LANE_W{pick_lo[LANE_W-1]}};
      end else begin : g_zero_fill
         assign fill_v = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_lo_q <= '0;
         res_hi_q <= '0;
      end else begin
         if (cap_first) begin
            res_lo_q <= pick_lo;
            res_hi_q <= kind.is_byte ? fill_v : lane_hi;
         end
         if (cap_second) begin
            res_hi_q <= lane_lo;
         end
      end
   end

   assign result = {res_hi_q, res_lo_q};

   // R4: the two captures of a split read never fall in the same cycle
   a_r4_capture_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_first && cap_second));

endmodule

// File: rtl/lane_merge_reader.sv
module lane_merge_reader
   import lmr_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int LANE_W    = 8,
   parameter bit SIGN_FILL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                req_byte,
   output logic                rsp_valid,
   input  logic                rsp_ready,
   output logic [2*LANE_W-1:0] rsp_data,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [ADDR_W-1:0]   mem_req_addr,
   input  logic                mem_rsp_valid,
   output logic                mem_rsp_ready,
   input  logic [2*LANE_W-1:0] mem_rsp_data
);

   localparam int DATA_W = 2 * LANE_W;

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("lane_merge_reader: ADDR_W must be at least 2");
      end
      if (LANE_W < 1) begin : g_bad_lane_w
         $error("lane_merge_reader: LANE_W must be at least 1");
      end
      if (DATA_W != 2 * LANE_W) begin : g_bad_data_w
         $error("lane_merge_reader: data path must hold two lanes");
      end
   endgenerate

   logic [ADDR_W-1:0] base_addr;
   logic              second_phase;
   lmr_kind_t         kind;
   logic              cap_first, cap_second;

   lmr_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_addr      (req_addr),
      .req_byte      (req_byte),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_ready (mem_rsp_ready),
      .rsp_valid     (rsp_valid),
      .rsp_ready     (rsp_ready),
      .base_addr     (base_addr),
      .second_phase  (second_phase),
      .kind          (kind),
      .cap_first     (cap_first),
      .cap_second    (cap_second)
   );

   lmr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .base_addr    (base_addr),
      .second_phase (second_phase),
      .bus_addr     (mem_req_addr)
   );

   lmr_lane_steer #(.LANE_W(LANE_W), .SIGN_FILL(SIGN_FILL)) u_steer (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .cap_first  (cap_first),
      .cap_second (cap_second),
      .bus_word   (mem_rsp_data),
      .result     (rsp_data)
   );

   // R2: bus addresses are word aligned
   a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !mem_req_addr[0]);

   // R9: no new request while a result is pending
   a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || mem_req_valid || mem_rsp_ready) |-> !req_ready);

   // R8: the result does not change while it waits to be taken
   a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> $stable(rsp_data));

   // R8: no result while a bus word is still awaited
   a_r8_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_ready |-> !rsp_valid);

endmodule

// File: tb/lane_merge_reader_tb.sv
`timescale 1ns/1ps
module lane_merge_reader_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [19:0] req_addr = '0;
   logic        req_byte = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [15:0] rsp_data;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [19:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic        mem_rsp_ready;
   logic [15:0] mem_rsp_data = '0;

   int checks = 0;
   int failures = 0;

   logic [15:0] exp_data[$];
   string       exp_tag[$];
   logic [19:0] exp_addr[$];
   string       exp_addr_tag[$];

   always #2 clk = ~clk;

   lane_merge_reader u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_byte(req_byte),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [15:0] memw(logic [19:0] a);
      logic [7:0] k;
      k = a[8:1] ^ a[19:12];
      return {(k ^ 8'hA5) + a[11:4], k ^ 8'h3C};
   endfunction

   function automatic logic [7:0] byte_at(logic [19:0] x);
      logic [15:0] w;
      w = memw({x[19:1], 1'b0});
      return x[0] ? w[15:8] : w[7:0];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // driver: pushes expected bus addresses and result, then offers the request
   task automatic issue(input logic [19:0] a, input bit is_byte);
      string tag;
      logic [19:0] al;
      al = {a[19:1], 1'b0};
      if (is_byte) tag = a[0] ? "R6" : "R5";
      else if (!a[0]) tag = "R3";
      else if (a == 20'hFFFFF) tag = "R7";
      else tag = "R4";
      exp_addr.push_back(al);
      exp_addr_tag.push_back(tag);
      if (!is_byte && a[0]) begin
         exp_addr.push_back(al + 20'd2);
         exp_addr_tag.push_back(tag);
      end
      if (is_byte) exp_data.push_back({8'h00, byte_at(a)});
      else exp_data.push_back({byte_at(a + 20'd1), byte_at(a)});
      exp_tag.push_back(tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_byte  = is_byte;
      forever begin
         if (req_ready) begin
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      req_addr  = $urandom;
      req_byte  = $urandom;
      // R9: busy right after acceptance
      check(req_ready == 1'b0, "R9", "req_ready after accept", {31'd0, req_ready}, 32'd0);
   endtask

   // memory model: checks every bus address against the expected list
   bit          pend = 0;
   logic [19:0] pend_addr;
   int          delay = 0;
   bit          rsp_taken = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_taken) begin
            mem_rsp_valid = 1'b0;
            rsp_taken = 0;
         end
         if (pend && !mem_rsp_valid) begin
            if (delay == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = memw(pend_addr);
               pend = 0;
            end else delay--;
         end
         if (mem_rsp_valid && mem_rsp_ready) rsp_taken = 1;
         mem_req_ready = ($urandom % 4) != 0;
         if (mem_req_valid && mem_req_ready) begin
            check(mem_req_addr[0] == 1'b0, "R2", "bus address bit 0",
                  {12'd0, mem_req_addr}, {12'd0, mem_req_addr & 20'hFFFFE});
            if (exp_addr.size() == 0) begin
               check(1'b0, "R3", "unexpected extra bus read", {12'd0, mem_req_addr}, 32'd0);
            end else begin
               logic [19:0] ea;
               string et;
               ea = exp_addr.pop_front();
               et = exp_addr_tag.pop_front();
               check(mem_req_addr == ea, et, "bus address", {12'd0, mem_req_addr}, {12'd0, ea});
            end
            pend = 1;
            pend_addr = mem_req_addr;
            delay = $urandom % 3;
         end
      end
   end

   // monitor: pops expected results as the unit delivers them
   bit          held = 0;
   logic [15:0] held_data;
   always @(negedge clk) begin
      if (rst_n) begin
         if (held) begin
            check(rsp_valid == 1'b1, "R8", "rsp_valid held", {31'd0, rsp_valid}, 32'd1);
            check(rsp_data == held_data, "R8", "rsp_data held", {16'd0, rsp_data}, {16'd0, held_data});
         end
         rsp_ready = ($urandom % 3) != 0;
         held = rsp_valid && !rsp_ready;
         held_data = rsp_data;
         if (rsp_valid && rsp_ready) begin
            if (exp_data.size() == 0) begin
               check(1'b0, "R8", "response with nothing expected", {16'd0, rsp_data}, 32'd0);
            end else begin
               logic [15:0] ed;
               string et;
               ed = exp_data.pop_front();
               et = exp_tag.pop_front();
               check(rsp_data == ed, et, "rsp_data", {16'd0, rsp_data}, {16'd0, ed});
            end
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: state during reset
      check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1",
            "reset outputs", {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1",
            "outputs after reset", {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'b100);

      issue(20'h00520, 1'b0);  // R3 even word
      issue(20'h00521, 1'b0);  // R4 odd word
      issue(20'h00520, 1'b1);  // R5 even byte
      issue(20'h00521, 1'b1);  // R6 odd byte
      issue(20'hFFFFF, 1'b0);  // R7 wrap
      issue(20'hFFFFE, 1'b0);  // R3 top even word
      issue(20'hFFFFF, 1'b1);  // R6 top odd byte
      issue(20'h00000, 1'b0);  // R3 bottom
      issue(20'h00001, 1'b0);  // R4 low odd word
      for (int i = 0; i < 80; i++) begin
         logic [19:0] a;
         a = $urandom;
         issue(a, $urandom % 2 == 1);
      end

      while (exp_data.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      check(exp_addr.size() == 0, "R4", "missing bus reads", exp_addr.size(), 32'd0);
      finish_run();
   end

endmodule